// File: doc/BRIEF.md
# Microcontroller Bus Glue Decoder

This block sits between the external bus of an 8-bit microcontroller and a voltage-monitoring front end made of two stages of analog multiplexers and an 8-bit A/D converter. It looks at the upper address byte and the active-low read and write strobes. From these it recognises four I/O locations: a read-only identity location, a channel-select register, a converter command location and a converter result location.

A read of the identity location returns a fixed byte, which lets firmware confirm that the glue logic is present and that the bus works. A write to the channel-select register stores the data byte. The stored byte then drives the front-stage channel select and the back-stage select. It also drives a one-hot set of enables for the front-stage multiplexers, decoded from the back-stage field. Accesses to the two converter locations produce the converter's active-low chip enable and chip select and its read/write direction line.

The bidirectional data bus appears as a separate input, a separate output and an output enable. The block drives the bus only while the identity location is being read. During a converter result read, the converter drives the bus instead.

Top module: `mcu_bus_glue`

## Requirements
- R1: While `rd_n` is low and `addr_hi` equals 0x07, `dout_oe` is high and `dout` equals 0xAA.
- R2: `dout_oe` is low whenever `rd_n` is high. It is also low during a read of any address other than 0x07, including 0x0B, 0x0C, 0x0E and undecoded addresses. While `dout_oe` is low, `dout` is 0x00.
- R3: A write to address 0x0B is captured on the rising (trailing) edge of `wr_n`. The new byte appears on the select outputs SYNC_STAGES+1 clock cycles after that edge. Until then the previous value is held, including for the whole time the strobe is low.
- R4: A write strobe at any address other than 0x0B leaves the channel-select register unchanged.
- R5: `front_sel` equals bits 2..0 and `back_sel` equals bits 7..5 of the stored byte. Bits 4..3 are stored but not used.
- R6: After a channel write, `mux_en` has exactly bit `back_sel` set when `back_sel` is 0 to 4, and is all zero when `back_sel` is 5, 6 or 7.
- R7: `adc_cs_n` is low exactly when `addr_hi` is 0x0C or 0x0E, whatever the strobes are doing.
- R8: `adc_ce_n` is low only when `addr_hi` is 0x0C or 0x0E and `rd_n` or `wr_n` is low. Otherwise it is high.
- R9: `adc_rw` is low when `addr_hi` is 0x0C (command write) and high for every other address, including 0x0E (result read).
- R10: After reset, the channel-select register holds 0x00, `front_sel` and `back_sel` are 0, and `mux_en` stays all zero until the first write to 0x0B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, used to sample the write strobe |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_hi | input | 8 | Upper byte of the microcontroller address |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 8 | Data bus, microcontroller to block |
| dout | output | 8 | Data bus, block to microcontroller |
| dout_oe | output | 1 | High while the block drives the data bus |
| adc_ce_n | output | 1 | Converter chip enable, active low |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rw | output | 1 | Converter direction: high = read result, low = write command |
| front_sel | output | 3 | Channel select of the front-stage multiplexers |
| back_sel | output | 3 | Channel select of the back-stage multiplexer |
| mux_en | output | 5 | Active-high enables of the five front-stage multiplexers |

## Verification
On every clock the assertions check the combinational bus relations:
- the identity byte and output enable during an identity read, and the enable never active without a read;
- converter enable only together with its chip select and a strobe;
- the direction line during a command access;
- a multiplexer enable set that is never more than one-hot and is empty for back-stage values above four.

Only the bench's scenarios can show the following:
- the trailing-edge capture and its exact latency;
- that the old selection holds throughout a strobe;
- that writes to other addresses leave the register alone;
- the dark enables between reset and the first channel write.

// File: rtl/glue_pkg.sv
package glue_pkg;

   // Kind of access recognised from the upper address byte
   typedef enum logic [2:0] {
      ACC_IDLE      = 3'd0,
      ACC_SELFTEST  = 3'd1,
      ACC_CHAN      = 3'd2,
      ACC_CONV_CMD  = 3'd3,
      ACC_CONV_DATA = 3'd4
   } acc_kind_t;

endpackage

// File: rtl/glue_addr_dec.sv
module glue_addr_dec
   import glue_pkg::*;
#(
   parameter int                AHI_W          = 8,
   parameter logic [AHI_W-1:0]  DEC_MASK       = '1,
   parameter logic [AHI_W-1:0]  ADDR_SELFTEST  = 8'h07,
   parameter logic [AHI_W-1:0]  ADDR_CHAN      = 8'h0B,
   parameter logic [AHI_W-1:0]  ADDR_CONV_CMD  = 8'h0C,
   parameter logic [AHI_W-1:0]  ADDR_CONV_DATA = 8'h0E
) (
   input  logic [AHI_W-1:0] addr_hi,
   output acc_kind_t        kind
);

   localparam logic [AHI_W-1:0] M_ST = ADDR_SELFTEST  & DEC_MASK;
   localparam logic [AHI_W-1:0] M_CH = ADDR_CHAN      & DEC_MASK;
   localparam logic [AHI_W-1:0] M_CC = ADDR_CONV_CMD  & DEC_MASK;
   localparam logic [AHI_W-1:0] M_CD = ADDR_CONV_DATA & DEC_MASK;

   // The masked locations must not alias one another
   if (M_ST == M_CH || M_ST == M_CC || M_ST == M_CD ||
       M_CH == M_CC || M_CH == M_CD || M_CC == M_CD) begin : g_alias_err
      $error("glue_addr_dec: decoded locations alias under DEC_MASK");
   end

   logic [AHI_W-1:0] masked;
   assign masked = addr_hi & DEC_MASK;

   always_comb begin
      if (masked == M_ST)      kind = ACC_SELFTEST;
      else if (masked == M_CH) kind = ACC_CHAN;
      else if (masked == M_CC) kind = ACC_CONV_CMD;
      else if (masked == M_CD) kind = ACC_CONV_DATA;
      else                     kind = ACC_IDLE;
   end

endmodule

// File: rtl/glue_wr_capture.sv
module glue_wr_capture #(
   parameter int                AHI_W       = 8,
   parameter int                DATA_W      = 8,
   parameter int                SYNC_STAGES = 2,
   parameter logic [AHI_W-1:0]  DEC_MASK    = '1,
   parameter logic [AHI_W-1:0]  ADDR_CHAN   = 8'h0B
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [AHI_W-1:0]  addr_hi,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] chan_q,
   output logic              chan_valid
);

   // Bundle of strobe, address and data carried through the sampler
   localparam int BW = 1 + AHI_W + DATA_W;
   localparam int WR_BIT = BW - 1;
   localparam int A_MSB  = BW - 2;
   localparam logic [BW-1:0] IDLE_BUNDLE = {1'b1, {(BW-1){1'b0}}};

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_sync_err
      $error("glue_wr_capture: SYNC_STAGES must lie in 1..4");
   end

   // stg[0..SYNC_STAGES-1] are the sampler stages; stg[SYNC_STAGES] is the
   // one-cycle-older copy used to find the trailing edge
   logic [SYNC_STAGES:0][BW-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i <= SYNC_STAGES; i++) stg[i] <= IDLE_BUNDLE;
      end else begin
         stg[0] <= {wr_n, addr_hi, din};
         for (int i = 1; i <= SYNC_STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   logic [BW-1:0]     newest;
   logic [BW-1:0]     older;
   logic              trail_edge;
   logic [AHI_W-1:0]  older_addr;
   logic [DATA_W-1:0] older_data;

   assign newest     = stg[SYNC_STAGES-1];
   assign older      = stg[SYNC_STAGES];
   assign trail_edge = !older[WR_BIT] && newest[WR_BIT];
   assign older_addr = older[A_MSB -: AHI_W];
   assign older_data = older[DATA_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chan_q     <= '0;
         chan_valid <= 1'b0;
      end else if (trail_edge && ((older_addr & DEC_MASK) == (ADDR_CHAN & DEC_MASK))) begin
         chan_q     <= older_data;
         chan_valid <= 1'b1;
      end
   end

endmodule

// File: rtl/glue_sel_decode.sv
module glue_sel_decode #(
   parameter int DATA_W   = 8,
   parameter int FSEL_LSB = 0,
   parameter int FSEL_W   = 3,
   parameter int BSEL_LSB = 5,
   parameter int BSEL_W   = 3,
   parameter int NUM_MUX  = 5
) (
   input  logic [DATA_W-1:0]  chan_q,
   input  logic               chan_valid,
   output logic [FSEL_W-1:0]  front_sel,
   output logic [BSEL_W-1:0]  back_sel,
   output logic [NUM_MUX-1:0] mux_en
);

   if (FSEL_LSB + FSEL_W > DATA_W || BSEL_LSB + BSEL_W > DATA_W) begin : g_field_err
      $error("glue_sel_decode: select field exceeds the data width");
   end
   if (NUM_MUX < 1 || NUM_MUX > (1 << BSEL_W)) begin : g_mux_err
      $error("glue_sel_decode: NUM_MUX does not fit the back-stage field");
   end

   assign front_sel = chan_q[FSEL_LSB +: FSEL_W];
   assign back_sel  = chan_q[BSEL_LSB +: BSEL_W];

   // One comparator per multiplexer; codes at or above NUM_MUX match none
   for (genvar g = 0; g < NUM_MUX; g++) begin : g_en
      assign mux_en[g] = chan_valid && (back_sel == BSEL_W'(g));
   end

endmodule

// File: rtl/mcu_bus_glue.sv
module mcu_bus_glue
   import glue_pkg::*;
#(
   parameter int                AHI_W          = 8,
   parameter int                DATA_W         = 8,
   parameter int                SYNC_STAGES    = 2,
   parameter int                NUM_MUX        = 5,
   parameter int                FSEL_LSB       = 0,
   parameter int                FSEL_W         = 3,
   parameter int                BSEL_LSB       = 5,
   parameter int                BSEL_W         = 3,
   parameter logic [AHI_W-1:0]  DEC_MASK       = '1,
   parameter logic [AHI_W-1:0]  ADDR_SELFTEST  = 8'h07,
   parameter logic [AHI_W-1:0]  ADDR_CHAN      = 8'h0B,
   parameter logic [AHI_W-1:0]  ADDR_CONV_CMD  = 8'h0C,
   parameter logic [AHI_W-1:0]  ADDR_CONV_DATA = 8'h0E,
   parameter logic [DATA_W-1:0] SELFTEST_CODE  = 8'hAA
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AHI_W-1:0]   addr_hi,
   input  logic               rd_n,
   input  logic               wr_n,
   input  logic [DATA_W-1:0]  din,
   output logic [DATA_W-1:0]  dout,
   output logic               dout_oe,
   output logic               adc_ce_n,
   output logic               adc_cs_n,
   output logic               adc_rw,
   output logic [FSEL_W-1:0]  front_sel,
   output logic [BSEL_W-1:0]  back_sel,
   output logic [NUM_MUX-1:0] mux_en
);

   acc_kind_t         kind;
   logic [DATA_W-1:0] chan_q;
   logic              chan_valid;
   logic              rd_act;
   logic              wr_act;
   logic              conv_hit;

   glue_addr_dec #(
      .AHI_W          (AHI_W),
      .DEC_MASK       (DEC_MASK),
      .ADDR_SELFTEST  (ADDR_SELFTEST),
      .ADDR_CHAN      (ADDR_CHAN),
      .ADDR_CONV_CMD  (ADDR_CONV_CMD),
      .ADDR_CONV_DATA (ADDR_CONV_DATA)
   ) u_dec (
      .addr_hi (addr_hi),
      .kind    (kind)
   );

   glue_wr_capture #(
      .AHI_W       (AHI_W),
      .DATA_W      (DATA_W),
      .SYNC_STAGES (SYNC_STAGES),
      .DEC_MASK    (DEC_MASK),
      .ADDR_CHAN   (ADDR_CHAN)
   ) u_cap (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_n       (wr_n),
      .addr_hi    (addr_hi),
      .din        (din),
      .chan_q     (chan_q),
      .chan_valid (chan_valid)
   );

   glue_sel_decode #(
      .DATA_W   (DATA_W),
      .FSEL_LSB (FSEL_LSB),
      .FSEL_W   (FSEL_W),
      .BSEL_LSB (BSEL_LSB),
      .BSEL_W   (BSEL_W),
      .NUM_MUX  (NUM_MUX)
   ) u_sel (
      .chan_q     (chan_q),
      .chan_valid (chan_valid),
      .front_sel  (front_sel),
      .back_sel   (back_sel),
      .mux_en     (mux_en)
   );

   assign rd_act   = !rd_n;
   assign wr_act   = !wr_n;
   assign conv_hit = (kind == ACC_CONV_CMD) || (kind == ACC_CONV_DATA);

   // Bus is driven only for the identity location
   assign dout_oe  = rd_act && (kind == ACC_SELFTEST);
   assign dout     = dout_oe ? SELFTEST_CODE : '0;

   // Converter controls
   assign adc_cs_n = !conv_hit;
   assign adc_ce_n = !(conv_hit && (rd_act || wr_act));
   assign adc_rw   = (kind != ACC_CONV_CMD);

endmodule

// File: rtl/glue_chk.sv
module glue_chk #(
   parameter int                AHI_W          = 8,
   parameter int                DATA_W         = 8,
   parameter int                NUM_MUX        = 5,
   parameter int                FSEL_W         = 3,
   parameter int                BSEL_W         = 3,
   parameter logic [AHI_W-1:0]  DEC_MASK       = '1,
   parameter logic [AHI_W-1:0]  ADDR_SELFTEST  = 8'h07,
   parameter logic [AHI_W-1:0]  ADDR_CONV_CMD  = 8'h0C,
   parameter logic [AHI_W-1:0]  ADDR_CONV_DATA = 8'h0E,
   parameter logic [DATA_W-1:0] SELFTEST_CODE  = 8'hAA
) (
   input logic               clk,
   input logic               rst_n,
   input logic [AHI_W-1:0]   addr_hi,
   input logic               rd_n,
   input logic               wr_n,
   input logic [DATA_W-1:0]  dout,
   input logic               dout_oe,
   input logic               adc_ce_n,
   input logic               adc_cs_n,
   input logic               adc_rw,
   input logic [BSEL_W-1:0]  back_sel,
   input logic [NUM_MUX-1:0] mux_en
);

   logic st_addr;
   logic cmd_addr;
   assign st_addr  = (addr_hi & DEC_MASK) == (ADDR_SELFTEST & DEC_MASK);
   assign cmd_addr = (addr_hi & DEC_MASK) == (ADDR_CONV_CMD & DEC_MASK);

   // R1
   selftest_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_n && st_addr) |-> (dout_oe && dout == SELFTEST_CODE));

   // R2
   oe_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dout_oe |-> (!rd_n && st_addr));

   // R6
   en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mux_en));

   // R6
   en_high_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(back_sel) >= NUM_MUX) |-> (mux_en == '0));

   // R8
   ce_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adc_ce_n |-> (!adc_cs_n && (!rd_n || !wr_n)));

   // R9
   rw_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_addr |-> !adc_rw);

endmodule

bind mcu_bus_glue glue_chk #(
   .AHI_W          (AHI_W),
   .DATA_W         (DATA_W),
   .NUM_MUX        (NUM_MUX),
   .FSEL_W         (FSEL_W),
   .BSEL_W         (BSEL_W),
   .DEC_MASK       (DEC_MASK),
   .ADDR_SELFTEST  (ADDR_SELFTEST),
   .ADDR_CONV_CMD  (ADDR_CONV_CMD),
   .ADDR_CONV_DATA (ADDR_CONV_DATA),
   .SELFTEST_CODE  (SELFTEST_CODE)
) u_glue_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .addr_hi  (addr_hi),
   .rd_n     (rd_n),
   .wr_n     (wr_n),
   .dout     (dout),
   .dout_oe  (dout_oe),
   .adc_ce_n (adc_ce_n),
   .adc_cs_n (adc_cs_n),
   .adc_rw   (adc_rw),
   .back_sel (back_sel),
   .mux_en   (mux_en)
);

// File: tb/tb_mcu_bus_glue.sv
module tb_mcu_bus_glue;

   localparam int SYNC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] addr_hi = 8'h00;
   logic       rd_n = 1'b1;
   logic       wr_n = 1'b1;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       dout_oe;
   logic       adc_ce_n;
   logic       adc_cs_n;
   logic       adc_rw;
   logic [2:0] front_sel;
   logic [2:0] back_sel;
   logic [4:0] mux_en;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [7:0] m_latch = 8'h00;
   bit         m_valid = 1'b0;

   always #2 clk = ~clk;

   mcu_bus_glue #(.SYNC_STAGES(SYNC)) dut (
      .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .rd_n(rd_n), .wr_n(wr_n),
      .din(din), .dout(dout), .dout_oe(dout_oe), .adc_ce_n(adc_ce_n),
      .adc_cs_n(adc_cs_n), .adc_rw(adc_rw), .front_sel(front_sel),
      .back_sel(back_sel), .mux_en(mux_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit is_conv(input logic [7:0] a);
      return (a == 8'h0C) || (a == 8'h0E);
   endfunction

   function automatic logic [4:0] exp_en(input logic [7:0] q, input bit v);
      logic [2:0] b;
      b = q[7:5];
      if (!v || b > 3'd4) return 5'b0;
      return 5'(1) << b;
   endfunction

   // R5 R6 R10: selects and enables follow the model register
   task automatic check_sel(input string tag);
      check({tag, " R5 front"}, 32'(front_sel), 32'(m_latch[2:0]));
      check({tag, " R5 back"},  32'(back_sel),  32'(m_latch[7:5]));
      check({tag, " R6 en"},    32'(mux_en),    32'(exp_en(m_latch, m_valid)));
   endtask

   task automatic check_conv(input string tag, input logic [7:0] a, input bit strobe);
      check({tag, " R7 cs_n"}, 32'(adc_cs_n), 32'(!is_conv(a)));
      check({tag, " R8 ce_n"}, 32'(adc_ce_n), 32'(!(is_conv(a) && strobe)));
      check({tag, " R9 rw"},   32'(adc_rw),   32'(a != 8'h0C));
   endtask

   task automatic do_read(input logic [7:0] a);
      @(negedge clk);
      addr_hi = a; rd_n = 1'b0;
      #1;
      // R1 R2
      check("R1/R2 oe", 32'(dout_oe), 32'(a == 8'h07));
      check("R1/R2 data", 32'(dout), (a == 8'h07) ? 32'hAA : 32'h00);
      check_conv("read", a, 1'b1);
      @(negedge clk);
      #1;
      check_sel("read R4");
      rd_n = 1'b1;
      #1;
      check("R2 idle oe", 32'(dout_oe), 32'd0);
      check_conv("read end", a, 1'b0);
      addr_hi = 8'h00;
   endtask

   task automatic do_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      addr_hi = a; din = d; wr_n = 1'b0;
      #1;
      check_conv("write", a, 1'b1);
      repeat (3) @(negedge clk);
      #1;
      // R3: old value held while strobe low
      check_sel("R3 during strobe");
      wr_n = 1'b1;
      repeat (SYNC) @(negedge clk);
      #1;
      // R3: not yet visible one cycle before the capture edge
      check_sel("R3 before capture");
      @(negedge clk);
      #1;
      if (a == 8'h0B) begin
         m_latch = d;
         m_valid = 1'b1;
      end
      // R3 R4
      check_sel((a == 8'h0B) ? "R3 captured" : "R4 ignored");
      addr_hi = 8'h00; din = 8'h00;
   endtask

   function automatic logic [7:0] pick_addr(input bit favour_chan);
      int r;
      r = int'($urandom_range(0, 5));
      case (r)
         0: return 8'h07;
         1: return favour_chan ? 8'h0B : 8'h0C;
         2: return 8'h0B;
         3: return 8'h0C;
         4: return 8'h0E;
         default: return 8'($urandom_range(0, 255));
      endcase
   endfunction

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual running expected finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R10: reset state
      check_sel("R10 reset");
      check("R10 en dark", 32'(mux_en), 32'd0);
      check("R2 reset oe", 32'(dout_oe), 32'd0);
      check_conv("reset", 8'h00, 1'b0);

      // R4 R10: non-channel writes keep enables dark
      do_write(8'h0C, 8'hE7);
      do_write(8'h0E, 8'h41);
      check("R10 still dark", 32'(mux_en), 32'd0);

      // R6 R10: first write of zero lights enable 0
      do_write(8'h0B, 8'h00);
      check("R6 first zero", 32'(mux_en), 32'd1);

      // R6: every back-stage code, front bits varied
      for (int b = 0; b < 8; b++) do_write(8'h0B, 8'((b << 5) | (7 - b) | 8'h18));

      // R1 R2 R7 R8 R9 directed reads
      do_read(8'h07);
      do_read(8'h0B);
      do_read(8'h0C);
      do_read(8'h0E);
      do_read(8'hFF);
      do_read(8'h06);

      // Random mix
      for (int i = 0; i < 300; i++) begin
         if ($urandom_range(0, 1) == 0) do_read(pick_addr(1'b0));
         else do_write(pick_addr(1'b1), 8'($urandom_range(0, 255)));
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule